// File: doc/BRIEF.md
# Gated Pulse Counter with Locking Edge Capture

This block counts pulses on one channel into a 16-bit register that can go up or down. A gate input can be set to enable counting only while it is high, only while it is low, or not at all. The count wraps at a programmable preset value when rollover is enabled; otherwise it uses the full 16-bit range. All asynchronous inputs pass through a two-stage synchroniser before any edge or level is used.

A capture unit copies the running count into a store register when a chosen edge occurs. The edge can be a rising edge of the index input, or a rising, falling or either edge of the gate input. After a capture the store-done flag stays set and no further capture is taken until software raises the store-clear bit. A separate flag records that the count has matched the preset. It is cleared by a rising edge of its own clear bit.

Top module: `gate_cap_counter`

## Requirements
- R1: A rising edge of `pulse_i` changes `count_o` by one step, up when `dir_i` is 0 and down when it is 1. The change appears at the third rising clock edge, counting the edge that first samples `pulse_i` high. `dir_i` goes through the same two-stage delay.
- R2: Gate mode `cfg_i[1:0]` works as follows. 00 and 11 ignore `gate_i`. 01 counts only while the synchronised `gate_i` is high. 10 counts only while it is low. Pulses that the gate blocks leave `count_o` unchanged.
- R3: With rollover enabled (`cfg_i[4]`=1), an up step from a count equal to `preset_i` gives 0.
- R4: With rollover disabled, an up step from 16'hFFFF gives 0 and a down step from 0 gives 16'hFFFF.
- R5: With rollover enabled, a down step from 0 loads `preset_i`.
- R6: Store mode `cfg_i[3:2]` picks the capture event from the synchronised inputs: 00 a rising edge of `index_i`, 01 a rising edge of `gate_i`, 10 a falling edge of `gate_i`, 11 either edge of `gate_i`. A capture copies the count as it stood before that clock's update.
- R7: A capture happens only while `store_done_o` is 0 and sets it to 1. While it is 1, capture events leave `stored_o` unchanged.
- R8: A rising edge of `cfg_i[5]` clears `store_done_o` at that clock. If a capture occurs at the same clock, the capture wins and the flag stays 1.
- R9: `reached_o` becomes 1 on the clock after `count_o` equals `preset_i`. A rising edge of `cfg_i[6]` clears it, but not while the count still equals the preset.
- R10: While `rst` is high at a clock edge, the count, stored value and both flags become 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pulse_i | input | 1 | Count pulse, asynchronous |
| dir_i | input | 1 | Count direction, 1 = down, asynchronous |
| index_i | input | 1 | Index input, asynchronous |
| gate_i | input | 1 | Gate input, asynchronous |
| cfg_i | input | 7 | [1:0] gate mode, [3:2] store mode, [4] rollover, [5] store-clear, [6] preset-flag clear |
| preset_i | input | 16 | Wrap and compare value |
| count_o | output | 16 | Running count |
| stored_o | output | 16 | Captured count |
| store_done_o | output | 1 | Capture taken, store locked |
| reached_o | output | 1 | Count has matched preset |

## Verification
Directed runs apply pulse trains in both directions, each under every gate mode with the gate held both high and low. This shows which mode honours which polarity. Wrap runs around a small preset and around 16'hFFFF, with rollover on and off, to show which wrap value each direction uses. The capture runs step through all four store modes with repeated edges, and place a store-clear edge at the same clock as a capture, to show the lock and its priority. A long random run then changes every input and configuration bit cycle by cycle, and a behavioural model is compared on every clock.

// File: rtl/gcc_pkg.sv
package gcc_pkg;

  typedef enum logic [1:0] {
    GATE_OFF  = 2'b00,
    GATE_HIGH = 2'b01,
    GATE_LOW  = 2'b10,
    GATE_RSVD = 2'b11
  } gate_mode_e;

  typedef enum logic [1:0] {
    CAP_IDX_RISE  = 2'b00,
    CAP_GATE_RISE = 2'b01,
    CAP_GATE_FALL = 2'b10,
    CAP_GATE_BOTH = 2'b11
  } store_mode_e;

  // Configuration word layout, MSB first: [6] flag clear, [5] store clear,
  // [4] rollover, [3:2] store mode, [1:0] gate mode
  typedef struct packed {
    logic        pclr;
    logic        sclr;
    logic        roll;
    store_mode_e store;
    gate_mode_e  gate;
  } cfg_t;

  localparam int CFG_W = $bits(cfg_t);

  // Synchronised input lanes
  localparam int LANE_PULSE = 0;
  localparam int LANE_DIR   = 1;
  localparam int LANE_IDX   = 2;
  localparam int LANE_GATE  = 3;
  localparam int LANES      = 4;

endpackage

// File: rtl/gcc_sync.sv
module gcc_sync #(
  parameter int N      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] lvl_o,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o
);

  logic [N-1:0] prev_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [N-1:0] q;
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= g_stage[s-1].q;
      end
    end
  end

  assign lvl_o = g_stage[STAGES-1].q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= lvl_o;
  end

  assign rise_o = lvl_o & ~prev_q;
  assign fall_o = ~lvl_o & prev_q;

endmodule

// File: rtl/gcc_count_core.sv
module gcc_count_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step_i,
  input  logic             down_i,
  input  logic             roll_i,
  input  logic [CNT_W-1:0] preset_i,
  input  logic             pclr_i,
  output logic [CNT_W-1:0] count_o,
  output logic             reached_o
);

  localparam logic [CNT_W-1:0] TOP_VAL = {CNT_W{1'b1}};

  logic [CNT_W-1:0] wrap_val;
  logic [CNT_W-1:0] count_nx;

  assign wrap_val = roll_i ? preset_i : TOP_VAL;

  always_comb begin
    count_nx = count_o;
    if (step_i) begin
      if (down_i) count_nx = (count_o == '0) ? wrap_val : count_o - 1'b1;
      else        count_nx = (count_o == wrap_val) ? '0 : count_o + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count_o   <= '0;
      reached_o <= 1'b0;
    end else begin
      count_o <= count_nx;
      if (count_o == preset_i) reached_o <= 1'b1;
      else if (pclr_i)         reached_o <= 1'b0;
    end
  end

endmodule

// File: rtl/gcc_capture.sv
module gcc_capture
  import gcc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  store_mode_e      mode_i,
  input  logic             idx_rise_i,
  input  logic             gate_rise_i,
  input  logic             gate_fall_i,
  input  logic             sclr_i,
  input  logic [CNT_W-1:0] count_i,
  output logic [CNT_W-1:0] stored_o,
  output logic             done_o
);

  logic hit;

  always_comb begin
    unique case (mode_i)
      CAP_IDX_RISE:  hit = idx_rise_i;
      CAP_GATE_RISE: hit = gate_rise_i;
      CAP_GATE_FALL: hit = gate_fall_i;
      CAP_GATE_BOTH: hit = gate_rise_i | gate_fall_i;
      default:       hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stored_o <= '0;
      done_o   <= 1'b0;
    end else if (hit && !done_o) begin
      stored_o <= count_i;
      done_o   <= 1'b1;
    end else if (sclr_i) begin
      done_o <= 1'b0;
    end
  end

endmodule

// File: rtl/gate_cap_counter.sv
module gate_cap_counter
  import gcc_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pulse_i,
  input  logic             dir_i,
  input  logic             index_i,
  input  logic             gate_i,
  input  logic [CFG_W-1:0] cfg_i,
  input  logic [CNT_W-1:0] preset_i,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-1:0] stored_o,
  output logic             store_done_o,
  output logic             reached_o
);

  cfg_t             cfg;
  logic [LANES-1:0] raw, lvl, rise, fall;
  logic             gate_ok;
  logic             step;
  logic             sclr_prev, pclr_prev;
  logic             sclr_edge, pclr_edge;

  assign cfg = cfg_t'(cfg_i);

  always_comb begin
    raw             = '0;
    raw[LANE_PULSE] = pulse_i;
    raw[LANE_DIR]   = dir_i;
    raw[LANE_IDX]   = index_i;
    raw[LANE_GATE]  = gate_i;
  end

  gcc_sync #(.N(LANES), .STAGES(SYNC_STAGES)) sync_i (
    .clk    (clk),
    .rst    (rst),
    .d_i    (raw),
    .lvl_o  (lvl),
    .rise_o (rise),
    .fall_o (fall)
  );

  always_comb begin
    unique case (cfg.gate)
      GATE_HIGH: gate_ok = lvl[LANE_GATE];
      GATE_LOW:  gate_ok = ~lvl[LANE_GATE];
      default:   gate_ok = 1'b1;
    endcase
  end

  assign step = rise[LANE_PULSE] & gate_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclr_prev <= 1'b0;
      pclr_prev <= 1'b0;
    end else begin
      sclr_prev <= cfg.sclr;
      pclr_prev <= cfg.pclr;
    end
  end

  assign sclr_edge = cfg.sclr & ~sclr_prev;
  assign pclr_edge = cfg.pclr & ~pclr_prev;

  gcc_count_core #(.CNT_W(CNT_W)) core_i (
    .clk       (clk),
    .rst       (rst),
    .step_i    (step),
    .down_i    (lvl[LANE_DIR]),
    .roll_i    (cfg.roll),
    .preset_i  (preset_i),
    .pclr_i    (pclr_edge),
    .count_o   (count_o),
    .reached_o (reached_o)
  );

  gcc_capture #(.CNT_W(CNT_W)) cap_i (
    .clk         (clk),
    .rst         (rst),
    .mode_i      (cfg.store),
    .idx_rise_i  (rise[LANE_IDX]),
    .gate_rise_i (rise[LANE_GATE]),
    .gate_fall_i (fall[LANE_GATE]),
    .sclr_i      (sclr_edge),
    .count_i     (count_o),
    .stored_o    (stored_o),
    .done_o      (store_done_o)
  );

endmodule

// File: rtl/gate_cap_counter_chk.sv
module gate_cap_counter_chk
  import gcc_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             pulse_i,
  input logic             dir_i,
  input logic             index_i,
  input logic             gate_i,
  input logic [CFG_W-1:0] cfg_i,
  input logic [CNT_W-1:0] preset_i,
  input logic [CNT_W-1:0] count_o,
  input logic [CNT_W-1:0] stored_o,
  input logic             store_done_o,
  input logic             reached_o
);

  // R10
  rst_clear_chk: assert property (@(posedge clk)
    rst |=> (count_o == '0 && stored_o == '0 && !store_done_o && !reached_o));

  // R7
  store_lock_chk: assert property (@(posedge clk) disable iff (rst)
    store_done_o |=> $stable(stored_o));

  // R8
  done_clear_src_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(store_done_o) |-> ($past(rst) || ($past(cfg_i[5]) && !$past(cfg_i[5], 2))));

  // R1
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    (count_o != $past(count_o)) |->
      (count_o == CNT_W'($past(count_o) + 1'b1) || count_o == CNT_W'($past(count_o) - 1'b1) ||
       count_o == '0 || count_o == $past(preset_i) || count_o == {CNT_W{1'b1}}));

  // R9
  reached_src_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(reached_o) |-> $past(count_o == preset_i));

endmodule

bind gate_cap_counter gate_cap_counter_chk #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) chk_i (.*);

// File: tb/gate_cap_counter_tb.sv
module gate_cap_counter_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pulse_i = 1'b0, dir_i = 1'b0, index_i = 1'b0, gate_i = 1'b0;
  logic [6:0]  cfg_i = '0;
  logic [15:0] preset_i = '0;
  logic [15:0] count_o, stored_o;
  logic        store_done_o, reached_o;

  int    total = 0;
  int    bad = 0;
  bit    finished = 1'b0;
  bit    cmp_on = 1'b0;
  string cur_req = "R10";

  always #5 clk = ~clk;

  gate_cap_counter dut_i (
    .clk(clk), .rst(rst), .pulse_i(pulse_i), .dir_i(dir_i), .index_i(index_i),
    .gate_i(gate_i), .cfg_i(cfg_i), .preset_i(preset_i), .count_o(count_o),
    .stored_o(stored_o), .store_done_o(store_done_o), .reached_o(reached_o)
  );

  // Behavioural reference: samples of {gate,index,dir,pulse} from the last three edges
  logic [3:0]  h1, h2, h3;
  logic [1:0]  cprev;
  logic [15:0] m_cnt, m_sto, wrapv, ncnt;
  logic        m_done, m_reach, prise, zrise, grise, gfall, gok, hit, ndone, nreach;
  logic [15:0] nsto;

  always @(posedge clk) begin
    if (rst) begin
      h1 = '0; h2 = '0; h3 = '0; cprev = '0;
      m_cnt = '0; m_sto = '0; m_done = 1'b0; m_reach = 1'b0;
    end else begin
      prise = h2[0] && !h3[0];
      zrise = h2[2] && !h3[2];
      grise = h2[3] && !h3[3];
      gfall = !h2[3] && h3[3];
      case (cfg_i[1:0])
        2'b01:   gok = h2[3];
        2'b10:   gok = !h2[3];
        default: gok = 1'b1;
      endcase
      wrapv = cfg_i[4] ? preset_i : 16'hFFFF;
      ncnt = m_cnt;
      if (prise && gok) begin
        if (h2[1]) ncnt = (m_cnt == 0) ? wrapv : m_cnt - 16'd1;
        else       ncnt = (m_cnt == wrapv) ? 16'd0 : m_cnt + 16'd1;
      end
      nreach = m_reach;
      if (m_cnt == preset_i)           nreach = 1'b1;
      else if (cfg_i[6] && !cprev[1])  nreach = 1'b0;
      case (cfg_i[3:2])
        2'b00:   hit = zrise;
        2'b01:   hit = grise;
        2'b10:   hit = gfall;
        default: hit = grise || gfall;
      endcase
      nsto = m_sto; ndone = m_done;
      if (hit && !m_done) begin nsto = m_cnt; ndone = 1'b1; end
      else if (cfg_i[5] && !cprev[0]) ndone = 1'b0;
      m_cnt = ncnt; m_sto = nsto; m_done = ndone; m_reach = nreach;
      h3 = h2; h2 = h1; h1 = {gate_i, index_i, dir_i, pulse_i};
      cprev = cfg_i[6:5];
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on && !finished) begin
      chk(cur_req, "model count",  32'(count_o),      32'(m_cnt));
      chk(cur_req, "model stored", 32'(stored_o),     32'(m_sto));
      chk(cur_req, "model done",   32'(store_done_o), 32'(m_done));
      chk(cur_req, "model reach",  32'(reached_o),    32'(m_reach));
    end
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      pulse_i = 1'b1; cyc(1);
      pulse_i = 1'b0; cyc(1);
    end
    cyc(4);
  endtask

  task automatic do_reset();
    rst = 1'b1; cyc(3); rst = 1'b0; cyc(1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    cyc(3);
    cmp_on = 1'b1;
    // R10: reset state
    cur_req = "R10";
    chk("R10", "count after reset", 32'(count_o), 0);
    chk("R10", "stored after reset", 32'(stored_o), 0);
    chk("R10", "done after reset", 32'(store_done_o), 0);
    rst = 1'b0; preset_i = 16'd100; cyc(2);

    // R1: up 5, down 2
    cur_req = "R1";
    pulses(5);
    chk("R1", "count up", 32'(count_o), 5);
    dir_i = 1'b1; pulses(2);
    chk("R1", "count down", 32'(count_o), 3);
    dir_i = 1'b0; cyc(4);

    // R2: gate modes
    cur_req = "R2";
    cfg_i[1:0] = 2'b01; gate_i = 1'b0; cyc(4); pulses(2);
    chk("R2", "mode01 gate low blocks", 32'(count_o), 3);
    gate_i = 1'b1; cyc(4); pulses(2);
    chk("R2", "mode01 gate high counts", 32'(count_o), 5);
    cfg_i[1:0] = 2'b10; pulses(2);
    chk("R2", "mode10 gate high blocks", 32'(count_o), 5);
    gate_i = 1'b0; cyc(4); pulses(1);
    chk("R2", "mode10 gate low counts", 32'(count_o), 6);
    cfg_i[1:0] = 2'b11; pulses(1); gate_i = 1'b1; cyc(4); pulses(1);
    chk("R2", "mode11 ignores gate", 32'(count_o), 8);
    cfg_i[1:0] = 2'b00; gate_i = 1'b0; cyc(4);

    // R3: rollover at preset
    cur_req = "R3";
    do_reset(); preset_i = 16'd4; cfg_i[4] = 1'b1; cyc(2);
    pulses(7);
    chk("R3", "wrap at preset", 32'(count_o), 2);

    // R5: down from 0 loads preset
    cur_req = "R5";
    do_reset(); dir_i = 1'b1; cyc(2); pulses(1);
    chk("R5", "down from 0 rollover", 32'(count_o), 4);
    dir_i = 1'b0; cyc(4);

    // R4: full range wrap
    cur_req = "R4";
    do_reset(); cfg_i[4] = 1'b0; dir_i = 1'b1; cyc(2); pulses(1);
    chk("R4", "down from 0 no rollover", 32'(count_o), 32'hFFFF);
    dir_i = 1'b0; cyc(4); pulses(1);
    chk("R4", "up from FFFF", 32'(count_o), 0);

    // R6 / R7: capture modes and lock
    cur_req = "R6";
    do_reset(); preset_i = 16'd500; cfg_i[3:2] = 2'b00; cyc(2);
    pulses(3);
    index_i = 1'b1; cyc(1); index_i = 1'b0; cyc(5);
    chk("R6", "index rise capture", 32'(stored_o), 3);
    chk("R7", "done set", 32'(store_done_o), 1);
    cur_req = "R7";
    pulses(2);
    index_i = 1'b1; cyc(1); index_i = 1'b0; cyc(5);
    chk("R7", "locked store", 32'(stored_o), 3);
    cur_req = "R8";
    cfg_i[5] = 1'b1; cyc(2);
    chk("R8", "store clear", 32'(store_done_o), 0);
    cfg_i[5] = 1'b0; cyc(1);
    cur_req = "R6";
    cfg_i[3:2] = 2'b01; gate_i = 1'b1; cyc(5);
    chk("R6", "gate rise capture", 32'(stored_o), 5);
    cfg_i[5] = 1'b1; cyc(1); cfg_i[5] = 1'b0; cyc(1);
    cfg_i[3:2] = 2'b10; pulses(1); gate_i = 1'b0; cyc(5);
    chk("R6", "gate fall capture", 32'(stored_o), 6);
    cfg_i[5] = 1'b1; cyc(1); cfg_i[5] = 1'b0; cyc(1);
    cfg_i[3:2] = 2'b11; pulses(1); gate_i = 1'b1; cyc(5);
    chk("R6", "both edges rise", 32'(stored_o), 7);
    cfg_i[5] = 1'b1; cyc(1); cfg_i[5] = 1'b0; cyc(1);
    pulses(1); gate_i = 1'b0; cyc(5);
    chk("R6", "both edges fall", 32'(stored_o), 8);
    cfg_i[5] = 1'b1; cyc(1); cfg_i[5] = 1'b0; cyc(1);

    // R8: capture and clear on the same clock
    cur_req = "R8";
    cfg_i[3:2] = 2'b01; pulses(1);
    gate_i = 1'b1; cyc(2); cfg_i[5] = 1'b1; cyc(3);
    chk("R8", "capture beats clear", 32'(store_done_o), 1);
    chk("R8", "stored on collision", 32'(stored_o), 9);
    cfg_i[5] = 1'b0; gate_i = 1'b0; cyc(4);

    // R9: preset reached flag
    cur_req = "R9";
    do_reset(); cfg_i = '0; preset_i = 16'd3; cyc(2);
    chk("R9", "flag clear below preset", 32'(reached_o), 0);
    pulses(3);
    chk("R9", "flag set at preset", 32'(reached_o), 1);
    cfg_i[6] = 1'b1; cyc(3);
    chk("R9", "set wins while equal", 32'(reached_o), 1);
    cfg_i[6] = 1'b0; pulses(1); cyc(1);
    cfg_i[6] = 1'b1; cyc(3);
    chk("R9", "flag cleared", 32'(reached_o), 0);
    cfg_i[6] = 1'b0;

    // Random run against the model, R1 to R10
    cur_req = "R1-rand";
    for (int i = 0; i < 4000; i++) begin
      pulse_i = 1'($urandom);
      dir_i   = ($urandom % 4) == 0;
      index_i = 1'($urandom);
      gate_i  = ($urandom % 3) == 0;
      if (($urandom % 16) == 0) cfg_i = 7'($urandom);
      else begin
        cfg_i[5] = ($urandom % 6) == 0;
        cfg_i[6] = ($urandom % 6) == 0;
      end
      if (($urandom % 64) == 0) preset_i = (($urandom % 4) == 0) ? 16'($urandom) : 16'($urandom % 8);
      rst = ($urandom % 500) == 0;
      cyc(1);
    end
    rst = 1'b0; cyc(4);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule